// File: doc/BRIEF.md
# Prioritized Nested Interrupt Controller

The block gathers interrupt requests from twelve external lines and four internal sources. Each source holds its own configuration: a vector, a 4-bit priority, a mask bit, a trigger type (level or rising edge) and a route. A source can be routed to the standard processor output, to the critical processor output, or to an off-chip pin. Every cycle, the block compares the pending, unmasked, enabled sources that are routed to the processor and picks the one with the highest priority.

The winning request is presented only if its priority is strictly above the task-priority threshold and strictly above the priority currently in service. An acknowledge pulse returns the winner's vector and pushes its priority onto an in-service stack. An end-of-interrupt pulse pops that stack. Because of this, a lower or equal request waits until the handlers above it have finished, and handling is fully nested. A summary vector shows the pending state of every source.

Top module: `pic_nested_ctrl`

## Requirements
- R1: After reset, irq_o, crit_o and ext_pin_o are 0, pend_o is 0, isr_pri_o is 0 and ack_vec_o is 0.
- R2: A level source (trigger bit 0) shows its input on pend_o one clock later. An edge source (trigger bit 1) sets its pending bit one clock after a rising edge of its input, and the bit stays set after the input falls.
- R3: A masked source still sets its pend_o bit, but it is never delivered on irq_o, crit_o or ext_pin_o.
- R4: A source with priority 0 is never delivered.
- R5: Among deliverable candidates, the highest priority wins. When priorities are equal, the lower source index wins.
- R6: A candidate is presented only if its priority is strictly greater than the task priority written through tpr_we_i.
- R7: A candidate is presented only if its priority is strictly greater than isr_pri_o, the top of the in-service stack (0 when the stack is empty).
- R8: Route code 0 drives irq_o and route code 1 drives crit_o. Route codes 2 and 3 drive ext_pin_o. ext_pin_o is the OR of every pending, unmasked, non-zero-priority source on those routes, it ignores the task priority and the in-service stack, and those sources are never acknowledged.
- R9: When ack_i is high while a request is presented, ack_vec_o holds the winner's vector on the next clock and isr_pri_o becomes the winner's priority. The winner's pending bit is cleared if it is an edge source and stays set if it is a level source.
- R10: When ack_i is high and nothing is presented, ack_vec_o becomes 8'hFF and the in-service stack is unchanged.
- R11: eoi_i pops the in-service stack one clock later, and pending requests are re-evaluated against the new top. eoi_i on an empty stack has no effect.
- R12: pend_o bit i belongs to source i. External line k is source k (0 to 11), and internal line k is source 12+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 12 | External request lines, sources 0 to 11 |
| int_irq_i | input | 4 | Internal request lines, sources 12 to 15 |
| cfg_we_i | input | 1 | Write the configuration of one source |
| cfg_idx_i | input | 4 | Source index for the configuration write |
| cfg_vec_i | input | 8 | Vector value |
| cfg_pri_i | input | 4 | Priority, 0 disables the source |
| cfg_mask_i | input | 1 | Mask bit |
| cfg_route_i | input | 2 | Route: 0 standard, 1 critical, 2 or 3 pin |
| cfg_edge_i | input | 1 | Trigger: 1 rising edge, 0 level |
| tpr_we_i | input | 1 | Write the task priority |
| tpr_i | input | 4 | Task priority value |
| ack_i | input | 1 | Acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| ack_vec_o | output | 8 | Vector returned by the last acknowledge |
| irq_o | output | 1 | Standard interrupt request |
| crit_o | output | 1 | Critical interrupt request |
| ext_pin_o | output | 1 | Request for off-chip handling |
| pend_o | output | 16 | Pending summary, one bit per source |
| isr_pri_o | output | 4 | Priority at the top of the in-service stack |

## Verification
The embedded properties check on every cycle that the two processor outputs are never high together and that a masked source is never presented. They also check that every push onto the in-service stack raises the in-service priority, that the stack never overflows, that an end-of-interrupt lowers the depth, and that acknowledging an edge source clears its pending bit. Only the bench scenarios can show which vector wins in a given situation: tie-breaking by index, the threshold compare, the order in which nested handlers return, spurious acknowledges, and the mapping of the lines onto the summary bits.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ROUTE_STD  = 2'd0,
    ROUTE_CRIT = 2'd1,
    ROUTE_PIN  = 2'd2,
    ROUTE_PIN2 = 2'd3
  } route_e;
endpackage

// File: rtl/pic_pend.sv
module pic_pend #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         pend_o[g] <= 1'b0;
      else if (edge_i[g])  pend_o[g] <= (pend_o[g] & ~clr_i[g]) | (req_i[g] & ~req_q[g]);
      else                 pend_o[g] <= req_i[g];
    end
  end
endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
  parameter int N     = 16,
  parameter int PRI_W = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            cand_i,
  input  logic [N-1:0][PRI_W-1:0] pri_i,
  output logic                    vld_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [PRI_W-1:0]        pri_o
);
  // strict compare while scanning upward keeps the lowest index on ties
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    pri_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && (!vld_o || pri_i[i] > pri_o)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
        pri_o = pri_i[i];
      end
    end
  end
endmodule

// File: rtl/pic_stack.sv
module pic_stack #(
  parameter int DEPTH = 16,
  parameter int PRI_W = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [PRI_W-1:0] push_pri_i,
  input  logic             pop_i,
  output logic [PRI_W-1:0] top_o
);
  logic [DEPTH-1:0][PRI_W-1:0] stk_q;
  logic [CW-1:0]               cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stk_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == cnt_q) stk_q[i] <= push_pri_i;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i + 1) == cnt_q) top_o = stk_q[i];
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CW'(DEPTH));
  p_pop_lowers_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_push_nests_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o > $past(top_o));
endmodule

// File: rtl/pic_nested_ctrl.sv
module pic_nested_ctrl #(
  parameter int          NUM_EXT   = 12,
  parameter int          NUM_INT   = 4,
  parameter int          PRI_W     = 4,
  parameter int          VEC_W     = 8,
  parameter int          STK_DEPTH = 16,
  parameter logic [7:0]  SPURIOUS  = 8'hFF,
  localparam int N     = NUM_EXT + NUM_INT,
  localparam int IDX_W = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_INT-1:0] int_irq_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [VEC_W-1:0]   cfg_vec_i,
  input  logic [PRI_W-1:0]   cfg_pri_i,
  input  logic               cfg_mask_i,
  input  logic [1:0]         cfg_route_i,
  input  logic               cfg_edge_i,
  input  logic               tpr_we_i,
  input  logic [PRI_W-1:0]   tpr_i,
  input  logic               ack_i,
  input  logic               eoi_i,
  output logic [VEC_W-1:0]   ack_vec_o,
  output logic               irq_o,
  output logic               crit_o,
  output logic               ext_pin_o,
  output logic [N-1:0]       pend_o,
  output logic [PRI_W-1:0]   isr_pri_o
);
  import pic_pkg::*;

  logic [N-1:0][VEC_W-1:0] vec_q;
  logic [N-1:0][PRI_W-1:0] pri_q;
  logic [N-1:0]            mask_q, edge_q, cand, pin_req, clr;
  route_e [N-1:0]          route_q;
  logic [PRI_W-1:0]        tpr_q, best_pri;
  logic [IDX_W-1:0]        best_idx;
  logic                    best_vld, deliver;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      pri_q   <= '0;
      mask_q  <= '1;
      edge_q  <= '0;
      route_q <= {N{ROUTE_STD}};
      tpr_q   <= '0;
    end else begin
      if (cfg_we_i) begin
        vec_q[cfg_idx_i]   <= cfg_vec_i;
        pri_q[cfg_idx_i]   <= cfg_pri_i;
        mask_q[cfg_idx_i]  <= cfg_mask_i;
        edge_q[cfg_idx_i]  <= cfg_edge_i;
        route_q[cfg_idx_i] <= route_e'(cfg_route_i);
      end
      if (tpr_we_i) tpr_q <= tpr_i;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_qual
    logic live;
    assign live       = pend_o[g] & ~mask_q[g] & (pri_q[g] != '0);
    assign cand[g]    = live & ~route_q[g][1];
    assign pin_req[g] = live &  route_q[g][1];
    assign clr[g]     = ack_i & deliver & edge_q[g] & (best_idx == IDX_W'(g));
  end

  pic_pend #(.N(N)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  ({int_irq_i, ext_irq_i}),
    .edge_i (edge_q),
    .clr_i  (clr),
    .pend_o (pend_o)
  );

  pic_arb #(.N(N), .PRI_W(PRI_W)) u_arb (
    .cand_i (cand),
    .pri_i  (pri_q),
    .vld_o  (best_vld),
    .idx_o  (best_idx),
    .pri_o  (best_pri)
  );

  pic_stack #(.DEPTH(STK_DEPTH), .PRI_W(PRI_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (ack_i & deliver),
    .push_pri_i (best_pri),
    .pop_i      (eoi_i & ~ack_i),
    .top_o      (isr_pri_o)
  );

  assign deliver   = best_vld && best_pri > tpr_q && best_pri > isr_pri_o;
  assign irq_o     = deliver && route_q[best_idx] == ROUTE_STD;
  assign crit_o    = deliver && route_q[best_idx] == ROUTE_CRIT;
  assign ext_pin_o = |pin_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ack_vec_o <= '0;
    else if (ack_i) ack_vec_o <= deliver ? vec_q[best_idx] : VEC_W'(SPURIOUS);
  end

  p_one_output_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && crit_o));
  p_mask_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || crit_o) |-> !mask_q[best_idx]);
  p_edge_ack_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && deliver && edge_q[best_idx]) |=> !pend_o[$past(best_idx)]);
endmodule

// File: tb/pic_nested_ctrl_tb.sv
module pic_nested_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ext_irq = '0;
  logic [3:0]  int_irq = '0;
  logic        cfg_we = 0, cfg_mask = 0, cfg_edge = 0, tpr_we = 0, ack = 0, eoi = 0;
  logic [3:0]  cfg_idx = '0, cfg_pri = '0, tpr = '0;
  logic [7:0]  cfg_vec = '0;
  logic [1:0]  cfg_route = '0;
  logic [7:0]  ack_vec;
  logic        irq, crit, pin;
  logic [15:0] pend;
  logic [3:0]  isr_pri;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pic_nested_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext_irq), .int_irq_i(int_irq),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_vec_i(cfg_vec), .cfg_pri_i(cfg_pri),
    .cfg_mask_i(cfg_mask), .cfg_route_i(cfg_route), .cfg_edge_i(cfg_edge),
    .tpr_we_i(tpr_we), .tpr_i(tpr), .ack_i(ack), .eoi_i(eoi),
    .ack_vec_o(ack_vec), .irq_o(irq), .crit_o(crit), .ext_pin_o(pin),
    .pend_o(pend), .isr_pri_o(isr_pri)
  );

  // {idx_a, pri_a, idx_b, pri_b, tpr, expected vector (FF = none)}
  localparam logic [27:0] VECS [8] = '{
    {4'd3,  4'd5,  4'd7,  4'd9,  4'd0,  8'h47},  // R5 higher wins
    {4'd2,  4'd6,  4'd9,  4'd6,  4'd0,  8'h42},  // R5 tie, lower index
    {4'd10, 4'd4,  4'd1,  4'd4,  4'd0,  8'h41},  // R5 tie, lower index
    {4'd5,  4'd3,  4'd6,  4'd2,  4'd3,  8'hFF},  // R6 equal to tpr blocked
    {4'd5,  4'd4,  4'd6,  4'd2,  4'd3,  8'h45},  // R6 above tpr
    {4'd0,  4'd0,  4'd11, 4'd0,  4'd0,  8'hFF},  // R4 priority 0
    {4'd14, 4'd15, 4'd0,  4'd14, 4'd14, 8'h4E},  // R6 internal source
    {4'd12, 4'd1,  4'd4,  4'd0,  4'd0,  8'h4C}   // R4 disabled neighbour
  };

  task automatic step(); @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic line(int idx, logic v);
    if (idx < 12) ext_irq[idx] = v; else int_irq[idx-12] = v;
  endtask

  task automatic cfg(int idx, logic [3:0] p, logic m, logic [1:0] r, logic e);
    cfg_we = 1; cfg_idx = 4'(idx); cfg_pri = p; cfg_mask = m; cfg_route = r;
    cfg_edge = e; cfg_vec = 8'(8'h40 + idx);
    step(); cfg_we = 0;
  endtask

  task automatic set_tpr(logic [3:0] v);
    tpr_we = 1; tpr = v; step(); tpr_we = 0;
  endtask

  task automatic pulse_ack(); ack = 1; step(); ack = 0; endtask
  task automatic pulse_eoi(); eoi = 1; step(); eoi = 0; endtask
  task automatic pulse_line(int idx); line(idx, 1); step(); line(idx, 0); endtask

  task automatic do_reset();
    ext_irq = '0; int_irq = '0;
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 outputs", {irq, crit, pin}, 0);
    chk("R1 pend", pend, 0);
    chk("R1 isr", isr_pri, 0);
    chk("R1 vec", ack_vec, 0);

    foreach (VECS[k]) begin
      automatic int ia = VECS[k][27:24], ib = VECS[k][19:16];
      automatic logic [7:0] ev = VECS[k][7:0];
      cfg(ia, VECS[k][23:20], 0, 0, 0);
      cfg(ib, VECS[k][15:12], 0, 0, 0);
      set_tpr(VECS[k][11:8]);
      line(ia, 1); line(ib, 1); step();
      chk("R5 R6 table irq", irq, ev != 8'hFF);
      pulse_ack();
      chk("R5 R10 table vec", ack_vec, ev);
      if (ev != 8'hFF) pulse_eoi();
      line(ia, 0); line(ib, 0);
      cfg(ia, 0, 0, 0, 0); cfg(ib, 0, 0, 0, 0);
      set_tpr(0);
    end

    // nesting with edge sources
    do_reset();
    cfg(1, 5, 0, 0, 1); cfg(2, 3, 0, 0, 1); cfg(3, 8, 0, 0, 1);
    line(1, 1); line(2, 1); step(); line(1, 0); line(2, 0); step();
    chk("R2 edge held", pend[3:1], 3'b011);
    chk("R7 irq", irq, 1);
    pulse_ack();
    chk("R9 vec", ack_vec, 8'h41);
    chk("R9 isr push", isr_pri, 5);
    chk("R9 edge cleared", pend[2:1], 2'b10);
    chk("R7 lower blocked", irq, 0);
    pulse_line(3);
    chk("R7 higher nests", irq, 1);
    pulse_ack();
    chk("R7 vec", ack_vec, 8'h43);
    chk("R7 isr", isr_pri, 8);
    pulse_eoi();
    chk("R11 pop", isr_pri, 5);
    chk("R11 still blocked", irq, 0);
    pulse_eoi();
    chk("R11 pop empty", isr_pri, 0);
    chk("R11 reevaluate", irq, 1);
    pulse_ack();
    chk("R9 vec late", ack_vec, 8'h42);
    pulse_eoi();
    pulse_eoi();
    chk("R11 empty eoi", isr_pri, 0);

    // level source not cleared by ack
    do_reset();
    cfg(4, 2, 0, 0, 0);
    line(4, 1); step();
    pulse_ack();
    chk("R9 level vec", ack_vec, 8'h44);
    chk("R9 level kept", pend[4], 1);
    pulse_eoi();
    line(4, 0); step();
    chk("R2 level follows", pend[4], 0);

    // mask and spurious
    do_reset();
    cfg(5, 7, 1, 0, 0);
    line(5, 1); step();
    chk("R3 pend", pend[5], 1);
    chk("R3 no irq", {irq, crit, pin}, 0);
    pulse_ack();
    chk("R10 spurious", ack_vec, 8'hFF);
    chk("R10 no push", isr_pri, 0);
    line(5, 0);

    // routes
    do_reset();
    cfg(6, 4, 0, 1, 0);
    line(6, 1); step();
    chk("R8 crit", {irq, crit}, 2'b01);
    pulse_ack();
    chk("R8 crit vec", ack_vec, 8'h46);
    pulse_eoi(); line(6, 0); step();
    cfg(7, 9, 0, 2, 0); set_tpr(15);
    line(7, 1); step();
    chk("R8 pin", {irq, crit, pin}, 3'b001);
    pulse_ack();
    chk("R8 pin not acked", ack_vec, 8'hFF);
    cfg(7, 9, 1, 3, 0); step();
    chk("R3 pin masked", pin, 0);
    line(7, 0);

    // summary mapping
    do_reset();
    int_irq[1] = 1; ext_irq[0] = 1; step();
    chk("R12 summary", pend, 16'h2001);
    chk("R4 unconfigured", {irq, crit, pin}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule